// File: doc/BRIEF.md
# Gated Serial Word Loader for a 12-bit DAC

This block is the digital input stage of a serial-fed 12-bit converter. A serial clock, an active-low frame strobe, a data line, an active-low load strobe and an active-low clear arrive as plain pins. A fast system clock samples them through two-flop synchronizers, and edge detection then runs in the system-clock domain. Each accepted falling edge of the serial clock shifts one data bit, most significant first, into a 16-bit frame register. The low 12 bits of that register form the converter word.

The block has two framing modes, chosen by a mode pin. In counted mode, a frame counter accepts exactly 16 serial clock falls after the frame strobe drops and ignores every fall after that. A free-running serial clock therefore loads the same word as a burst of 16 pulses. In chain mode the counter no longer gates the clock. Every fall while the frame strobe is low shifts the register, and the bit pushed out of the top is presented on a serial output at the next serial clock rise, so that the next device in a chain can take it.

A falling edge of the load strobe copies the 12-bit field into the output latch, but only once 16 bits have arrived since the last frame start. The clear pin zeroes the latch at once.

Top module: `dac_serial_loader`

## Requirements
- R1: After reset, `dac_word` is 0 and `sdo` is 0.
- R2: In counted mode (`chain_en`=0), a frame carries bit 15 first and bit 0 last. After a falling edge on `load_n`, `dac_word` equals bits 11..0 of the 16-bit frame, and bits 15..12 do not matter.
- R3: In counted mode, serial clock falls after the 16th in one frame have no effect. A continuous clock and a 16-pulse burst therefore give the same `dac_word`.
- R4: Serial clock falls while `sync_n` is high do not shift the frame register.
- R5: A falling edge of `sync_n` restarts the bit count. If fewer than 16 bits have arrived since that edge, a load falling edge leaves `dac_word` unchanged.
- R6: `dac_word` changes only on a load falling edge or on clear. A completed frame without a load leaves it unchanged.
- R7: A low level on `clr_n` forces `dac_word` to 0 without waiting for a clock edge. The frame register is not affected, so a later load without a new frame restores the previous word.
- R8: In chain mode (`chain_en`=1), every serial clock fall while `sync_n` is low shifts the register. On the following serial clock rise, `sdo` takes the bit that left bit 15. After 16 or more shifts, a load takes the 12 most recent bits.
- R9: In counted mode, `sdo` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock pin; data is taken on its falling edge |
| sync_n | input | 1 | Active-low frame strobe pin |
| sdata | input | 1 | Serial data pin |
| chain_en | input | 1 | Mode select: 0 counted, 1 chain |
| load_n | input | 1 | Load strobe pin; the latch updates on its falling edge |
| clr_n | input | 1 | Active-low asynchronous latch clear |
| sdo | output | 1 | Chained serial output |
| dac_word | output | 12 | Latched converter word |

## Verification
Directed frames test the plain 16-pulse burst against a free-running clock that keeps toggling after the word, which shows whether the counter gate works. Clock pulses while the frame strobe is high, short frames followed by a load, and frames with no load show whether anything outside the counted window leaks into the register or the latch. A clear followed by a reload without a new frame shows that the clear reaches the latch but not the frame register. Chain-mode frames longer than 16 bits check `sdo` after every rise and then check the final word, and seeded random words with random extra pulses in both modes are compared against a bench shift model.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  localparam int FRAME_W_DEF = 16;
  localparam int DAC_W_DEF   = 12;

  typedef enum logic {
    MODE_COUNTED = 1'b0,
    MODE_CHAIN   = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int              W       = 4,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= RST_VAL;
      else        stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import dsl_pkg::*;
#(
  parameter int FRAME_W = FRAME_W_DEF,
  parameter int DAC_W   = DAC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  frame_mode_e      mode,
  input  logic             sync_lo,
  input  logic             sync_fall,
  input  logic             sclk_fall,
  input  logic             sclk_rise,
  input  logic             sdata,
  output logic [DAC_W-1:0] dac_bits,
  output logic             word_ok,
  output logic             sdo
);
  localparam int              CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [CNT_W-1:0]   cnt, cnt_base;
  logic [FRAME_W-1:0] sreg;
  logic               pend;
  logic               gate_open;
  logic               shift_evt;

  function automatic logic gate_allows(input frame_mode_e m,
                                       input logic [CNT_W-1:0] c);
    return (m == MODE_CHAIN) || (c < FULL);
  endfunction

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return (c == FULL) ? FULL : c + 1'b1;
  endfunction

  assign cnt_base  = sync_fall ? '0 : cnt;
  assign gate_open = gate_allows(mode, cnt_base);
  assign shift_evt = sclk_fall && sync_lo && gate_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sreg <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= shift_evt ? count_step(cnt_base) : cnt_base;
      if (shift_evt) begin
        pend <= sreg[FRAME_W-1];
        sreg <= {sreg[FRAME_W-2:0], sdata};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sdo <= 1'b0;
    else if (mode != MODE_CHAIN) sdo <= 1'b0;
    else if (sclk_rise)          sdo <= pend;
  end

  assign word_ok  = (cnt == FULL);
  assign dac_bits = sreg[DAC_W-1:0];

  a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  a_r3_gated_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_COUNTED && cnt == FULL && !sync_fall) |=> $stable(sreg));
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_lo |=> $stable(sreg));
  a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fall |=> (cnt <= CNT_W'(1)));
  a_r9_counted_sdo: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_COUNTED) |=> !sdo);
endmodule

// File: rtl/dac_latch.sv
module dac_latch #(
  parameter int DAC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_evt,
  input  logic             word_ok,
  input  logic [DAC_W-1:0] din,
  output logic [DAC_W-1:0] word
);
  logic arst_n;
  logic take;

  assign arst_n = rst_n & clr_n;
  assign take   = load_evt && word_ok;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   word <= '0;
    else if (take) word <= din;
  end

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (word == '0));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && clr_n) |=> ($stable(word) || !clr_n));
  a_r5_reject_short: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !word_ok && clr_n) |=> ($stable(word) || !clr_n));
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader
  import dsl_pkg::*;
#(
  parameter int FRAME_W     = FRAME_W_DEF,
  parameter int DAC_W       = DAC_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sync_n,
  input  logic             sdata,
  input  logic             chain_en,
  input  logic             load_n,
  input  logic             clr_n,
  output logic             sdo,
  output logic [DAC_W-1:0] dac_word
);
  // synchronized vector: {chain, data, load, sync, sclk}
  localparam int         NPIN    = 5;
  localparam int         NEDGE   = 3;
  localparam logic [4:0] PIN_IDLE = 5'b00111;

  logic [NPIN-1:0]  pins_s;
  logic [NEDGE-1:0] prev_q, fall;
  logic             sclk_rise;
  frame_mode_e      mode;
  logic [DAC_W-1:0] dac_bits;
  logic             word_ok;

  pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({chain_en, sdata, load_n, sync_n, sclk}),
    .dout (pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= PIN_IDLE[NEDGE-1:0];
    else        prev_q <= pins_s[NEDGE-1:0];
  end

  assign fall      = prev_q & ~pins_s[NEDGE-1:0];
  assign sclk_rise = ~prev_q[0] & pins_s[0];
  assign mode      = frame_mode_e'(pins_s[4]);

  frame_shifter #(.FRAME_W(FRAME_W), .DAC_W(DAC_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .sync_lo  (~pins_s[1]),
    .sync_fall(fall[1]),
    .sclk_fall(fall[0]),
    .sclk_rise(sclk_rise),
    .sdata    (pins_s[3]),
    .dac_bits (dac_bits),
    .word_ok  (word_ok),
    .sdo      (sdo)
  );

  dac_latch #(.DAC_W(DAC_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .load_evt(fall[2]),
    .word_ok (word_ok),
    .din     (dac_bits),
    .word    (dac_word)
  );

  a_r1_reset_out: assert property (@(posedge clk)
    !rst_n |=> (dac_word == '0 && sdo == 1'b0));
endmodule

// File: tb/dac_serial_loader_bench.sv
`timescale 1ns/1ps
module dac_serial_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdata = 1'b0, chain_en = 1'b0;
  logic load_n = 1'b1, clr_n = 1'b1;
  logic sdo;
  logic [11:0] dac_word;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_reg = '0;   // bench shift model
  int          m_cnt = 0;
  logic        m_out = 1'b0;
  logic [11:0] exp_word = '0;

  always #2.5 clk = ~clk;

  dac_serial_loader u_dac_serial_loader (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdata(sdata),
    .chain_en(chain_en), .load_n(load_n), .clr_n(clr_n),
    .sdo(sdo), .dac_word(dac_word)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, expv);
    end
  endtask

  function automatic logic frame_bit(input logic [15:0] w, input int i);
    return (i < 16) ? w[15-i] : 1'b0;
  endfunction

  // one serial clock pulse; updates bench model per the requirements
  task automatic pulse(input logic b, input logic framed, input string req);
    sdata = b;
    wait_n(3);
    sclk = 1'b0;
    if (framed && (chain_en || m_cnt < 16)) begin
      m_out = m_reg[15];
      m_reg = {m_reg[14:0], b};
      if (m_cnt < 16) m_cnt++;
    end
    wait_n(3);
    sclk = 1'b1;
    wait_n(6);
    if (chain_en) chk(req, {15'd0, sdo}, {15'd0, m_out});
  endtask

  task automatic frame(input logic [15:0] w, input int nedges, input string req);
    sync_n = 1'b0;
    m_cnt  = 0;
    wait_n(4);
    for (int i = 0; i < nedges; i++) begin
      if (i < 16) pulse(frame_bit(w, i), 1'b1, req);
      else        pulse(1'($urandom_range(0, 1)), 1'b1, req);
    end
    sync_n = 1'b1;
    wait_n(4);
  endtask

  task automatic do_load();
    load_n = 1'b0;
    if (m_cnt >= 16) exp_word = m_reg[11:0];
    wait_n(8);
    load_n = 1'b1;
    wait_n(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1", {4'd0, dac_word}, 16'h0);
    chk("R1", {15'd0, sdo}, 16'h0);

    // R2: burst of exactly 16
    frame(16'hA5C3, 16, "R2");
    do_load();
    chk("R2", {4'd0, dac_word}, 16'h5C3);
    chk("R9", {15'd0, sdo}, 16'h0);

    // R3: continuous clock with 9 extra edges
    frame(16'h3E71, 25, "R3");
    do_load();
    chk("R3", {4'd0, dac_word}, 16'hE71);

    // R4: pulses with sync high are ignored
    for (int i = 0; i < 6; i++) pulse(1'(i & 1), 1'b0, "R4");
    do_load();
    chk("R4", {4'd0, dac_word}, 16'hE71);

    // R5: short frame, load rejected; then full frame accepted
    frame(16'hFFFF, 9, "R5");
    do_load();
    chk("R5", {4'd0, dac_word}, 16'hE71);
    frame(16'h0123, 16, "R5");
    do_load();
    chk("R5", {4'd0, dac_word}, 16'h123);

    // R6: complete frame without load
    frame(16'h0BAD, 16, "R6");
    chk("R6", {4'd0, dac_word}, 16'h123);

    // R7: asynchronous clear, then reload without a new frame
    do_load();
    chk("R6", {4'd0, dac_word}, 16'hBAD);
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    chk("R7", {4'd0, dac_word}, 16'h0);
    wait_n(4);
    clr_n = 1'b1;
    wait_n(4);
    chk("R7", {4'd0, dac_word}, 16'h0);
    do_load();
    chk("R7", {4'd0, dac_word}, 16'hBAD);

    // R8: chain mode, 20 edges, sdo checked on each rise
    chain_en = 1'b1;
    wait_n(6);
    frame(16'hC0DE, 20, "R8");
    do_load();
    chk("R8", {4'd0, dac_word}, {4'd0, m_reg[11:0]});

    // random mix of modes and frame lengths
    for (int t = 0; t < 24; t++) begin
      chain_en = 1'($urandom_range(0, 1));
      wait_n(6);
      frame(16'($urandom()), int'($urandom_range(10, 22)), chain_en ? "R8" : "R3");
      do_load();
      chk(chain_en ? "R8" : "R2", {4'd0, dac_word}, {4'd0, exp_word});
      if (!chain_en) chk("R9", {15'd0, sdo}, 16'h0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule